// File: doc/BRIEF.md
# Serial Line Transmitter with Bus-Driver Enable

This block turns bytes offered on a ready/valid input into asynchronous serial frames on a single output line. The frame format is chosen at run time. It covers five to eight data bits, sent least significant bit first after one low start bit. It adds an optional parity bit and one, one-and-a-half or two stop bits. The line idles high. Bit timing comes from two strobes supplied by a divider elsewhere in the chip. `frac_tick` pulses sixteen times per bit time. `baud_tick` marks every bit boundary and coincides with every sixteenth `frac_tick`. A new frame only starts on a `baud_tick`. Bit and stop lengths are counted in `frac_tick` pulses, which allows a half-bit final stop.

The block can also hold the line low as a break. A break lasts for a programmed number of `ms_tick` pulses, or until a stop pulse when the programmed length is zero. A break request that arrives during a frame waits until that frame ends. A driver-enable output for a half-duplex differential transceiver is active during every frame and every break. It then stays active for one further bit time, and that hold time restarts after each frame. Its polarity is selectable.

Top module: `uart485_tx`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then parity if enabled, then the stop bits at high level. `cfg_len` code k (0 to 3) selects k+5 data bits. The line is high whenever no frame or break is being sent.
- R2: The `cfg_par` codes are 0 none, 1 even (parity bit makes the count of ones over data and parity even), 2 odd, 3 mark (parity bit always 1) and 4 space (always 0). Codes 5 to 7 send no parity bit.
- R3: `cfg_stop` code 0 gives one stop bit and codes 2 and 3 give two. Code 1 gives one full stop bit followed by a half stop bit (8 `frac_tick` pulses) when `cfg_len` is 0. With any other length, code 1 falls back to two stop bits.
- R4: Every bit other than a half stop lasts 16 `frac_tick` pulses. `in_ready` is high only while `baud_tick` is high and no break is pending. It also needs the transmitter to be idle, holding the enable, or ending a frame's final full stop bit on that same tick. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The start bit appears on the line from the next cycle.
- R5: A `brk_req` pulse latches `brk_len`. Once no frame is in progress, the line is driven low. It is released when the `brk_len`-th `ms_tick` pulse arrives. No byte is accepted while a break is pending.
- R6: With `brk_len` zero, the break lasts until a `brk_stop` pulse. A `brk_stop` pulse while a break is still pending cancels it, and the line stays high.
- R7: The enable is active during every frame and break, and for 16 further `frac_tick` pulses after each ends. A frame accepted within that hold keeps the enable active without a gap.
- R8: `cfg_de_low` at 0 makes `de` active high. At 1 it makes `de` active low.
- R9: After reset, `txd` is high, `de` is inactive, no break is pending and `in_ready` follows `baud_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frac_tick | input | 1 | Strobe, sixteen per bit time |
| baud_tick | input | 1 | Strobe on each bit boundary |
| ms_tick | input | 1 | Strobe once per millisecond |
| cfg_len | input | 2 | Data length code (k+5 bits) |
| cfg_stop | input | 2 | Stop length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_de_low | input | 1 | Driver enable is active low when set |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte taken this cycle if valid |
| brk_req | input | 1 | Pulse: request a break |
| brk_len | input | 7 | Break length in ms ticks, 0 = until stopped |
| brk_stop | input | 1 | Pulse: end or cancel a break |
| txd | output | 1 | Serial line |
| de | output | 1 | Transceiver driver enable |

## Verification
The bench sends bytes at every data length, under all five parity modes and with each stop setting, including the 1.5-stop fallback. A mismatch in these frames separates errors in bit order, masking of the parity sum and half-bit timing. A pair of bytes with `in_valid` held shows whether the next start bit follows the final stop directly and whether the enable stays on. Breaks are tried in three ways: a timed break requested in the middle of a frame, an open-ended break closed by a stop pulse, and a break cancelled while still pending. These distinguish the deferral, the ms count and the stop handling. A run with the inverted enable checks the polarity on its own.

// File: rtl/uart485_tx_pkg.sv
package uart485_tx_pkg;

    localparam int unsigned DATA_MAX = 8;
    localparam int unsigned FRAME_W  = 1 + DATA_MAX + 1 + 2;
    localparam int unsigned NBITS_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_BREAK = 2'd2,
        ST_HOLD  = 2'd3
    } tx_state_e;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NBITS_W-1:0] nbits;
        logic               half_last;
    } frame_t;

    function automatic logic par_bit(input logic [7:0] masked, input logic [2:0] code);
        case (code)
            PAR_EVEN: par_bit = ^masked;
            PAR_ODD:  par_bit = ~^masked;
            PAR_MARK: par_bit = 1'b1;
            default:  par_bit = 1'b0;
        endcase
    endfunction

    function automatic frame_t build_frame(input logic [7:0] d,
                                           input logic [1:0] len_code,
                                           input logic [1:0] stop_code,
                                           input logic [2:0] par_code);
        frame_t     f;
        logic [3:0] n;
        logic [7:0] mask;
        logic       has_p;
        logic       two;
        n     = 4'd5 + {2'b00, len_code};
        mask  = 8'hFF >> (4'd8 - n);
        has_p = (par_code != 3'd0) && (par_code <= 3'd4);
        two   = (stop_code != 2'd0);
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(n)) f.bits[i+1] = d[i];
        end
        if (has_p) f.bits[4'(n + 4'd1)] = par_bit(d & mask, par_code);
        f.half_last = (stop_code == 2'd1) && (len_code == 2'd0);
        f.nbits     = NBITS_W'(4'd1 + n + {3'b000, has_p} + (two ? 4'd2 : 4'd1));
        return f;
    endfunction

endpackage

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
    import uart485_tx_pkg::*;
(
    input  logic [7:0] data,
    input  logic [1:0] len_code,
    input  logic [1:0] stop_code,
    input  logic [2:0] par_code,
    output frame_t     frame
);
    always_comb frame = build_frame(data, len_code, stop_code, par_code);
endmodule

// File: rtl/tx_break_timer.sv
module tx_break_timer #(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             brk_req,
    input  logic [LEN_W-1:0] brk_len,
    input  logic             brk_stop,
    input  logic             ms_tick,
    input  logic             brk_start,
    input  logic             in_break,
    output logic             brk_pend,
    output logic             brk_end
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             timed_done;

    assign timed_done = ms_tick && (len_q != '0) && (cnt_q == len_q - LEN_W'(1));
    assign brk_end    = in_break && (brk_stop || timed_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_pend <= 1'b0;
            len_q    <= '0;
            cnt_q    <= '0;
        end else begin
            if (brk_stop) begin
                brk_pend <= 1'b0;
            end else if (brk_req) begin
                brk_pend <= 1'b1;
                len_q    <= brk_len;
            end
            if (brk_start) begin
                brk_pend <= 1'b0;
                cnt_q    <= '0;
            end else if (in_break && ms_tick) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/tx_engine.sv
module tx_engine
    import uart485_tx_pkg::*;
#(
    parameter int unsigned SUB_PER_BIT = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frac_tick,
    input  logic      baud_tick,
    input  logic      in_valid,
    input  frame_t    frame,
    input  logic      brk_pend,
    input  logic      brk_end,
    output logic      in_ready,
    output logic      brk_start,
    output tx_state_e state,
    output logic      line
);
    localparam int unsigned SUB_W = $clog2(SUB_PER_BIT);
    localparam logic [SUB_W-1:0] FULL_LAST = SUB_W'(SUB_PER_BIT - 1);
    localparam logic [SUB_W-1:0] HALF_LAST = SUB_W'(SUB_PER_BIT / 2 - 1);

    logic [FRAME_W-1:0] sr_q;
    logic [NBITS_W-1:0] nleft_q;
    logic [SUB_W-1:0]   sub_q;
    logic               half_q;
    logic               last_bit;
    logic               bit_done;
    logic               end_on_grid;
    logic               accept;

    assign last_bit    = (nleft_q == NBITS_W'(1));
    assign bit_done    = frac_tick && (sub_q == ((last_bit && half_q) ? HALF_LAST : FULL_LAST));
    assign end_on_grid = (state == ST_SEND) && last_bit && !half_q && bit_done;
    assign in_ready    = !brk_pend && baud_tick &&
                         ((state == ST_IDLE) || (state == ST_HOLD) || end_on_grid);
    assign accept      = in_valid && in_ready;
    assign brk_start   = brk_pend && ((state == ST_IDLE) || (state == ST_HOLD));
    assign line        = (state == ST_SEND) ? sr_q[0] : (state != ST_BREAK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sr_q    <= '1;
            nleft_q <= '0;
            sub_q   <= '0;
            half_q  <= 1'b0;
        end else if (accept) begin
            state   <= ST_SEND;
            sr_q    <= frame.bits;
            nleft_q <= frame.nbits;
            half_q  <= frame.half_last;
            sub_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (brk_start) state <= ST_BREAK;
                end
                ST_HOLD: begin
                    if (brk_start) begin
                        state <= ST_BREAK;
                    end else if (frac_tick) begin
                        if (sub_q == FULL_LAST) begin
                            state <= ST_IDLE;
                            sub_q <= '0;
                        end else begin
                            sub_q <= sub_q + SUB_W'(1);
                        end
                    end
                end
                ST_SEND: begin
                    if (bit_done) begin
                        sub_q <= '0;
                        if (last_bit) begin
                            state <= ST_HOLD;
                        end else begin
                            sr_q    <= {1'b1, sr_q[FRAME_W-1:1]};
                            nleft_q <= nleft_q - NBITS_W'(1);
                        end
                    end else if (frac_tick) begin
                        sub_q <= sub_q + SUB_W'(1);
                    end
                end
                default: begin
                    if (brk_end) begin
                        state <= ST_HOLD;
                        sub_q <= '0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tx_de_drive.sv
module tx_de_drive
    import uart485_tx_pkg::*;
(
    input  tx_state_e state,
    input  logic      active_low,
    output logic      de
);
    assign de = (state != ST_IDLE) ^ active_low;
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
    import uart485_tx_pkg::*;
#(
    parameter int unsigned SUB_PER_BIT = 16,
    parameter int unsigned BRK_LEN_W   = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frac_tick,
    input  logic                 baud_tick,
    input  logic                 ms_tick,
    input  logic [1:0]           cfg_len,
    input  logic [1:0]           cfg_stop,
    input  logic [2:0]           cfg_par,
    input  logic                 cfg_de_low,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    input  logic                 brk_req,
    input  logic [BRK_LEN_W-1:0] brk_len,
    input  logic                 brk_stop,
    output logic                 txd,
    output logic                 de
);
    frame_t    frm;
    tx_state_e st;
    logic      brk_pend;
    logic      brk_end;
    logic      brk_start;
    logic      in_break;

    assign in_break = (st == ST_BREAK);

    tx_frame_pack u_pack (
        .data(in_data), .len_code(cfg_len), .stop_code(cfg_stop),
        .par_code(cfg_par), .frame(frm)
    );

    tx_break_timer #(.LEN_W(BRK_LEN_W)) u_brk (
        .clk(clk), .rst(rst), .brk_req(brk_req), .brk_len(brk_len),
        .brk_stop(brk_stop), .ms_tick(ms_tick), .brk_start(brk_start),
        .in_break(in_break), .brk_pend(brk_pend), .brk_end(brk_end)
    );

    tx_engine #(.SUB_PER_BIT(SUB_PER_BIT)) u_eng (
        .clk(clk), .rst(rst), .frac_tick(frac_tick), .baud_tick(baud_tick),
        .in_valid(in_valid), .frame(frm), .brk_pend(brk_pend), .brk_end(brk_end),
        .in_ready(in_ready), .brk_start(brk_start), .state(st), .line(txd)
    );

    tx_de_drive u_de (.state(st), .active_low(cfg_de_low), .de(de));
endmodule

// File: rtl/uart485_tx_chk.sv
module uart485_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic de,
    input logic cfg_de_low,
    input logic in_break,
    input logic brk_pend
);
    logic de_on;
    assign de_on = (de != cfg_de_low);

    p_ready_on_grid_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> baud_tick);

    p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !txd);

    p_pend_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        brk_pend |-> !in_ready);

    p_break_low_r5: assert property (@(posedge clk) disable iff (rst)
        in_break |-> !txd);

    p_de_covers_low_r7: assert property (@(posedge clk) disable iff (rst)
        !txd |-> de_on);

    p_de_release_high_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(de_on) |-> (txd && $past(txd)));
endmodule

bind uart485_tx uart485_tx_chk u_chk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .txd(txd), .de(de), .cfg_de_low(cfg_de_low),
    .in_break(in_break), .brk_pend(brk_pend)
);

// File: tb/sim_uart485_tx.sv
module sim_uart485_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frac_tick = 1'b0, baud_tick = 1'b0, ms_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
    logic [2:0] cfg_par = 3'd0;
    logic       cfg_de_low = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       brk_req = 1'b0, brk_stop = 1'b0;
    logic [6:0] brk_len = 7'd0;
    logic       txd, de;

    int checks = 0, fails = 0;
    int cyc = 0;
    string cur_req = "R9";

    localparam int MS_CYC = 200;

    always #2 clk = ~clk;

    uart485_tx u0 (
        .clk(clk), .rst(rst), .frac_tick(frac_tick), .baud_tick(baud_tick),
        .ms_tick(ms_tick), .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_par(cfg_par),
        .cfg_de_low(cfg_de_low), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .brk_req(brk_req), .brk_len(brk_len),
        .brk_stop(brk_stop), .txd(txd), .de(de)
    );

    always @(negedge clk) begin
        cyc++;
        frac_tick = (cyc % 2 == 0);
        baud_tick = (cyc % 32 == 0);
        ms_tick   = (cyc % MS_CYC == 0);
    end

    // reference model: 0 idle, 1 frame, 2 break, 3 enable hold
    int m_mode = 0, m_hrem = 0, m_ms = 0, m_blen = 0;
    bit m_pend = 0, m_half = 0;
    int lvl_q[$];
    int dur_q[$];

    function automatic bit m_ready();
        if (m_pend || !baud_tick) return 0;
        if (m_mode == 0 || m_mode == 3) return 1;
        if (m_mode == 1 && lvl_q.size() == 1 && !m_half && dur_q[0] == 1 && frac_tick) return 1;
        return 0;
    endfunction

    function automatic void m_load();
        int n, ones;
        n = 5 + int'(cfg_len);
        ones = 0;
        lvl_q.delete(); dur_q.delete(); m_half = 0;
        lvl_q.push_back(0); dur_q.push_back(16);
        for (int i = 0; i < n; i++) begin
            lvl_q.push_back(int'(in_data[i])); dur_q.push_back(16);
            ones += int'(in_data[i]);
        end
        case (cfg_par)
            3'd1: begin lvl_q.push_back(ones % 2); dur_q.push_back(16); end
            3'd2: begin lvl_q.push_back(1 - ones % 2); dur_q.push_back(16); end
            3'd3: begin lvl_q.push_back(1); dur_q.push_back(16); end
            3'd4: begin lvl_q.push_back(0); dur_q.push_back(16); end
            default: ;
        endcase
        lvl_q.push_back(1); dur_q.push_back(16);
        if (cfg_stop == 2'd1 && n == 5) begin
            lvl_q.push_back(1); dur_q.push_back(8); m_half = 1;
        end else if (cfg_stop != 2'd0) begin
            lvl_q.push_back(1); dur_q.push_back(16);
        end
        m_mode = 1;
    endfunction

    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            m_mode = 0; m_pend = 0; m_hrem = 0; m_ms = 0; m_blen = 0;
            lvl_q.delete(); dur_q.delete();
        end else begin
            acc = in_valid && m_ready();
            case (m_mode)
                0, 3: begin
                    if (m_pend) begin m_mode = 2; m_pend = 0; m_ms = 0; end
                    else if (acc) m_load();
                    else if (m_mode == 3 && frac_tick) begin
                        m_hrem--;
                        if (m_hrem == 0) m_mode = 0;
                    end
                end
                1: if (frac_tick) begin
                    dur_q[0] = dur_q[0] - 1;
                    if (dur_q[0] == 0) begin
                        void'(lvl_q.pop_front()); void'(dur_q.pop_front());
                        if (lvl_q.size() == 0) begin
                            if (acc) m_load();
                            else begin m_mode = 3; m_hrem = 16; end
                        end
                    end
                end
                default: begin
                    if (brk_stop) begin m_mode = 3; m_hrem = 16; end
                    else if (ms_tick) begin
                        m_ms++;
                        if (m_blen != 0 && m_ms == m_blen) begin m_mode = 3; m_hrem = 16; end
                    end
                end
            endcase
            if (brk_stop) m_pend = 0;
            else if (brk_req) begin m_pend = 1; m_blen = int'(brk_len); end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            int etx;
            int ede;
            etx = (m_mode == 1) ? lvl_q[0] : ((m_mode != 2) ? 1 : 0);
            ede = ((m_mode != 0) ? 1 : 0) ^ int'(cfg_de_low);
            check(int'(txd) == etx, cur_req, "txd", int'(txd), etx);
            check(int'(de) == ede, (cur_req == "R8") ? "R8" : "R7", "de", int'(de), ede);
            check(in_ready == m_ready(), "R4", "in_ready", int'(in_ready), int'(m_ready()));
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk); in_valid = 1'b1; in_data = d;
        forever begin #1; if (in_ready) break; @(negedge clk); end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic send_pair(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = a;
        forever begin #1; if (in_ready) break; @(negedge clk); end
        @(negedge clk); in_data = b;
        forever begin #1; if (in_ready) break; @(negedge clk); end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic fmt(input logic [1:0] l, input logic [1:0] s, input logic [2:0] p);
        @(negedge clk); cfg_len = l; cfg_stop = s; cfg_par = p;
    endtask

    task automatic settle(); repeat (500) @(negedge clk); endtask

    task automatic pulse_req(input logic [6:0] len);
        @(negedge clk); brk_req = 1'b1; brk_len = len;
        @(negedge clk); brk_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); brk_stop = 1'b1;
        @(negedge clk); brk_stop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        #1;
        check(txd == 1'b1, "R9", "reset txd", int'(txd), 1);
        check(de == 1'b0, "R9", "reset de", int'(de), 0);
        repeat (40) @(negedge clk);
        cur_req = "R1";
        fmt(2'd3, 2'd0, 3'd0); send(8'hA5); settle();
        fmt(2'd0, 2'd0, 3'd0); send(8'h13); settle();
        cur_req = "R2";
        fmt(2'd2, 2'd0, 3'd1); send(8'h55); settle();
        fmt(2'd2, 2'd0, 3'd2); send(8'h2C); settle();
        fmt(2'd3, 2'd0, 3'd3); send(8'h00); settle();
        fmt(2'd3, 2'd0, 3'd4); send(8'hFF); settle();
        fmt(2'd1, 2'd0, 3'd1); send(8'hE7); settle();
        fmt(2'd3, 2'd0, 3'd6); send(8'h81); settle();
        cur_req = "R3";
        fmt(2'd0, 2'd1, 3'd1); send(8'h1B); settle();
        fmt(2'd3, 2'd1, 3'd0); send(8'h3C); settle();
        fmt(2'd1, 2'd2, 3'd2); send(8'h2A); settle();
        cur_req = "R7";
        fmt(2'd3, 2'd0, 3'd0); send_pair(8'h96, 8'h69); settle();
        fmt(2'd0, 2'd1, 3'd0); send_pair(8'h0F, 8'h11); settle();
        cur_req = "R5";
        fmt(2'd3, 2'd0, 3'd0); send(8'hC3);
        repeat (20) @(negedge clk);
        pulse_req(7'd3);
        repeat (1200) @(negedge clk);
        cur_req = "R6";
        pulse_req(7'd0);
        repeat (500) @(negedge clk);
        #1;
        check(txd == 1'b0, "R6", "open break line", int'(txd), 0);
        pulse_stop(); settle();
        send(8'h5A);
        repeat (10) @(negedge clk);
        pulse_req(7'd2);
        pulse_stop();
        repeat (1200) @(negedge clk);
        #1;
        check(txd == 1'b1, "R6", "cancelled break line", int'(txd), 1);
        cur_req = "R8";
        @(negedge clk); cfg_de_low = 1'b1;
        #1;
        check(de == 1'b1, "R8", "idle de inverted", int'(de), 1);
        send(8'h77); settle();
        @(negedge clk); cfg_de_low = 1'b0;
        settle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule